// File: doc/BRIEF.md
# Nibble-Register BCD Real-Time Clock

This block keeps the time of day and the calendar as separate binary-coded-decimal digits. Each digit sits in its own 4-bit register that a host reads and writes over a 16-address, 4-bit register bus. A 1 Hz tick enable advances the seconds. The carry then ripples through the minutes, hours, day, weekday, month and year. A 64 Hz tick enable from the same external prescaler drives the fastest periodic interrupt and ends the standard-mode pulse.

The host reads a consistent set of digits with a hold handshake. It sets the hold bit, checks the busy bit, and reads the digits only when busy is clear. While hold is set, the counter is frozen and one 1 Hz increment is kept pending. That increment is applied in the first clock after hold is released. Three control registers choose the 12-hour or 24-hour format and give stop and reset controls. They also request a 30-second adjust and select the periodic interrupt interval, its latching mode and its output mask.

Top module: `nibble_rtc`

## Requirements
- R1: After reset the clock reads 00:00:00 on day 01, month 01, year 00, weekday 0. Register 0xF reads 0x4 (24-hour mode). Registers 0xD and 0xE read 0x0.
- R2: The digit registers sit at these addresses: 0x0/0x1 seconds units/tens, 0x2/0x3 minutes, 0x4/0x5 hours, 0x6/0x7 day, 0x8/0x9 month, 0xA/0xB year, 0xC weekday. Register 0xD has bit 3 adjust request, bit 2 interrupt flag, bit 1 busy (read-only) and bit 0 hold. Register 0xE has bits 3:2 interval, bit 1 latch mode and bit 0 mask. Register 0xF has bit 3 test (stored only), bit 2 24-hour, bit 1 stop and bit 0 reset. Written values read back.
- R3: Each 1 Hz tick adds one second. The carry ripples 59→00 into the minutes and hours. In 24-hour mode the hours wrap 23→00 into the day. The weekday then steps 6→0, the month 12→01 and the year 99→00.
- R4: The day wraps to 01 after 28 or 29 days in February (29 when the year is a multiple of 4), after 30 in April, June, September and November, and after 31 in the other months.
- R5: In 12-hour mode (0xF bit 2 = 0), register 0x5 holds PM in bit 2 and the tens of hours in bits 1:0. 11:59:59 PM steps to 12:00:00 AM and advances the day. 12:59:59 steps to 01:00:00. 11:59:59 AM steps to 12:00:00 PM.
- R6: While hold is 1, no digit changes. Any number of ticks leaves exactly one pending increment, and busy reads 1. The pending increment is applied one clock after hold is cleared.
- R7: After each applied update, busy reads 1 for BUSY_CYC clocks and then returns to 0.
- R8: Writing 1 to 0xD bit 3 zeroes the seconds one clock later (hold clear). If the seconds were 30 or more, the minutes also advance. The request bit then reads 0.
- R9: While stop (0xF bit 1) is 1, 1 Hz ticks do not change the time.
- R10: While the reset control (0xF bit 0) is 1, the seconds read 00 and ticks do not advance them.
- R11: The interrupt flag (0xD bit 2) is set by the interval that 0xE bits 3:2 select: 00 every 64 Hz tick, 01 every second, 10 when the seconds wrap to 00, 11 when minutes and seconds both wrap.
- R12: With 0xE bit 1 = 1 the flag stays set until the host writes 0xD with bit 2 = 0. With 0xE bit 1 = 0 the flag clears at the next 64 Hz tick.
- R13: irq_out follows the flag when 0xE bit 0 = 0 and is held low when it is 1. The flag still sets while irq_out is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz_en | input | 1 | One-clock enable, once per second |
| tick_64hz_en | input | 1 | One-clock enable, 64 times per second |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Periodic interrupt output |

## Verification
A wrong carry decision stays hidden until the next tick that crosses that digit boundary. The directed cases therefore preload each boundary (month ends, leap February, year 99, the 12-hour crossings) one second before it and read every digit right after the tick. Errors in the hold and pending logic show within a clock of releasing hold, as a missing or doubled seconds step. A miscounted busy window shows as a busy bit that stays up or drops too early when read a fixed number of clocks after the update. Interrupt-latch errors show at irq_out on the first tick after an event or after the host clears the flag.

// File: rtl/nibble_rtc.sv
module nibble_rtc #(
  parameter int BUSY_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz_en,
  input  logic       tick_64hz_en,
  input  logic [3:0] bus_addr,
  input  logic       bus_we,
  input  logic [3:0] bus_wdata,
  output logic [3:0] bus_rdata,
  output logic       irq_out
);
  localparam int BW = $clog2(BUSY_CYC + 1);

  logic [3:0] sec_u, min_u, hr_u, day_u, mon_u, yr_u, yr_t;
  logic [2:0] sec_t, min_t, wday;
  logic [1:0] hr_t, day_t;
  logic       mon_t, pm;
  logic       adj_req, irq_flag, hold, pend;
  logic [3:0] ctl_e, ctl_f;
  logic [BW-1:0] busy_cnt;

  function automatic logic [6:0] b2(input logic [3:0] t, input logic [3:0] u);
    return 7'(t) * 7'd10 + 7'(u);
  endfunction

  function automatic logic [7:0] tob(input logic [6:0] v);
    logic [6:0] q, r;
    q = v / 7'd10;
    r = v % 7'd10;
    return {q[3:0], r[3:0]};
  endfunction

  wire mode24 = ctl_f[2];
  wire stop   = ctl_f[1];
  wire crst   = ctl_f[0];
  wire wr_d   = bus_we && bus_addr == 4'hD;
  wire busy   = pend || busy_cnt != '0;

  wire [6:0] sec_v = b2({1'b0, sec_t}, sec_u);
  wire [6:0] min_v = b2({1'b0, min_t}, min_u);
  wire [6:0] hr_v  = b2({2'b0, hr_t}, hr_u);
  wire [6:0] day_v = b2({2'b0, day_t}, day_u);
  wire [6:0] mon_v = b2({3'b0, mon_t}, mon_u);
  wire [6:0] yr_v  = b2(yr_t, yr_u);

  wire run_tick   = tick_1hz_en && !stop && !crst;
  wire adj_go     = adj_req && !hold;
  wire apply_step = !hold && !stop && !crst && (pend || tick_1hz_en) && !adj_go;

  logic [6:0] mdays;
  always_comb begin
    case (mon_v)
      7'd2:                      mdays = (yr_v[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   mdays = 7'd30;
      default:                   mdays = 7'd31;
    endcase
  end

  wire c_min   = (apply_step && sec_v == 7'd59) || (adj_go && sec_v >= 7'd30);
  wire c_hr    = c_min && min_v == 7'd59;
  wire hr_last = mode24 ? (hr_v == 7'd23) : (pm && hr_v == 7'd11);
  wire c_day   = c_hr && hr_last;
  wire c_mon   = c_day && day_v >= mdays;
  wire c_yr    = c_mon && mon_v >= 7'd12;

  wire [6:0] sec_n = (adj_go || sec_v == 7'd59) ? 7'd0 : sec_v + 7'd1;
  wire [6:0] min_n = (min_v == 7'd59) ? 7'd0 : min_v + 7'd1;
  wire [6:0] hr_n  = mode24 ? ((hr_v >= 7'd23) ? 7'd0 : hr_v + 7'd1)
                            : ((hr_v == 7'd12) ? 7'd1 : hr_v + 7'd1);
  wire       pm_n  = (!mode24 && hr_v == 7'd11) ? !pm : pm;
  wire [6:0] day_n = c_mon ? 7'd1 : day_v + 7'd1;
  wire [6:0] mon_n = (mon_v >= 7'd12) ? 7'd1 : mon_v + 7'd1;
  wire [6:0] yr_n  = (yr_v == 7'd99) ? 7'd0 : yr_v + 7'd1;
  wire [2:0] wday_n = (wday >= 3'd6) ? 3'd0 : wday + 3'd1;

  wire [7:0] sec_nb = tob(sec_n);
  wire [7:0] min_nb = tob(min_n);
  wire [7:0] hr_nb  = tob(hr_n);
  wire [7:0] day_nb = tob(day_n);
  wire [7:0] mon_nb = tob(mon_n);
  wire [7:0] yr_nb  = tob(yr_n);

  logic event_hit;
  always_comb begin
    case (ctl_e[3:2])
      2'b00:   event_hit = tick_64hz_en && !stop;
      2'b01:   event_hit = apply_step;
      2'b10:   event_hit = apply_step && sec_v == 7'd59;
      default: event_hit = apply_step && sec_v == 7'd59 && min_v == 7'd59;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_u <= '0; sec_t <= '0; min_u <= '0; min_t <= '0;
      hr_u <= '0; hr_t <= '0; pm <= 1'b0;
      day_u <= 4'd1; day_t <= '0; mon_u <= 4'd1; mon_t <= 1'b0;
      yr_u <= '0; yr_t <= '0; wday <= '0;
    end else begin
      if (apply_step || adj_go) begin
        sec_t <= sec_nb[6:4]; sec_u <= sec_nb[3:0];
      end
      if (crst) begin
        sec_t <= '0; sec_u <= '0;
      end
      if (c_min) begin
        min_t <= min_nb[6:4]; min_u <= min_nb[3:0];
      end
      if (c_hr) begin
        hr_t <= hr_nb[5:4]; hr_u <= hr_nb[3:0]; pm <= pm_n;
      end
      if (c_day) begin
        day_t <= day_nb[5:4]; day_u <= day_nb[3:0]; wday <= wday_n;
      end
      if (c_mon) begin
        mon_t <= mon_nb[4]; mon_u <= mon_nb[3:0];
      end
      if (c_yr) begin
        yr_t <= yr_nb[7:4]; yr_u <= yr_nb[3:0];
      end
      if (bus_we) begin
        case (bus_addr)
          4'h0: sec_u <= bus_wdata;
          4'h1: sec_t <= bus_wdata[2:0];
          4'h2: min_u <= bus_wdata;
          4'h3: min_t <= bus_wdata[2:0];
          4'h4: hr_u  <= bus_wdata;
          4'h5: begin hr_t <= bus_wdata[1:0]; pm <= bus_wdata[2]; end
          4'h6: day_u <= bus_wdata;
          4'h7: day_t <= bus_wdata[1:0];
          4'h8: mon_u <= bus_wdata;
          4'h9: mon_t <= bus_wdata[0];
          4'hA: yr_u  <= bus_wdata;
          4'hB: yr_t  <= bus_wdata;
          4'hC: wday  <= bus_wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_req <= 1'b0; irq_flag <= 1'b0; hold <= 1'b0; pend <= 1'b0;
      ctl_e <= 4'h0; ctl_f <= 4'h4; busy_cnt <= '0;
    end else begin
      if (crst)                            pend <= 1'b0;
      else if (run_tick && (hold || adj_go)) pend <= 1'b1;
      else if (apply_step)                 pend <= 1'b0;

      if (apply_step || adj_go)  busy_cnt <= BW'(BUSY_CYC);
      else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;

      if (wr_d)        adj_req <= bus_wdata[3];
      else if (adj_go) adj_req <= 1'b0;

      if (wr_d) hold <= bus_wdata[0];

      if (event_hit)                    irq_flag <= 1'b1;
      else if (!ctl_e[1] && tick_64hz_en) irq_flag <= 1'b0;
      else if (wr_d && !bus_wdata[2])   irq_flag <= 1'b0;

      if (bus_we && bus_addr == 4'hE) ctl_e <= bus_wdata;
      if (bus_we && bus_addr == 4'hF) ctl_f <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      4'h0: bus_rdata = sec_u;
      4'h1: bus_rdata = {1'b0, sec_t};
      4'h2: bus_rdata = min_u;
      4'h3: bus_rdata = {1'b0, min_t};
      4'h4: bus_rdata = hr_u;
      4'h5: bus_rdata = {1'b0, pm && !mode24, hr_t};
      4'h6: bus_rdata = day_u;
      4'h7: bus_rdata = {2'b0, day_t};
      4'h8: bus_rdata = mon_u;
      4'h9: bus_rdata = {3'b0, mon_t};
      4'hA: bus_rdata = yr_u;
      4'hB: bus_rdata = yr_t;
      4'hC: bus_rdata = {1'b0, wday};
      4'hD: bus_rdata = {adj_req, irq_flag, busy, hold};
      4'hE: bus_rdata = ctl_e;
      default: bus_rdata = ctl_f;
    endcase
  end

  assign irq_out = irq_flag && !ctl_e[0];

  // R6
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !bus_we && !crst) |=> $stable({sec_t, sec_u, min_t, min_u, hr_t, hr_u}));

  // R6
  pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !hold && !stop && !crst && !adj_req && !bus_we) |=> !pend);

  // R8
  adj_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_req && !hold && !bus_we) |=> !adj_req);

  // R10
  crst_sec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crst && !bus_we) |=> (sec_u == 4'd0 && sec_t == 3'd0));

  // R11
  irq_second_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_step && ctl_e[3:2] == 2'b01) |=> irq_flag);

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !pend && !adj_req && !bus_we) |=> $stable({sec_t, sec_u}));
endmodule

// File: tb/nibble_rtc_tb.sv
module nibble_rtc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz_en = 1'b0, tick_64hz_en = 1'b0;
  logic [3:0] bus_addr = 4'h0, bus_wdata = 4'h0;
  logic bus_we = 1'b0;
  logic [3:0] bus_rdata;
  logic irq_out;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  nibble_rtc #(.BUSY_CYC(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz_en(tick_1hz_en), .tick_64hz_en(tick_64hz_en),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic irq_chk(input logic exp, input string req);
    @(negedge clk);
    #1;
    chk(req, {3'b0, irq_out}, {3'b0, exp});
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk); tick_1hz_en = 1'b1;
    @(negedge clk); tick_1hz_en = 1'b0;
  endtask

  task automatic tick64();
    @(negedge clk); tick_64hz_en = 1'b1;
    @(negedge clk); tick_64hz_en = 1'b0;
  endtask

  task automatic set_all(input logic [3:0] ht, hu, mt, mu, st, su, dt, du, ot, ou, yt, yu, w);
    wr(4'h5, ht); wr(4'h4, hu); wr(4'h3, mt); wr(4'h2, mu);
    wr(4'h1, st); wr(4'h0, su); wr(4'h7, dt); wr(4'h6, du);
    wr(4'h9, ot); wr(4'h8, ou); wr(4'hB, yt); wr(4'hA, yu); wr(4'hC, w);
  endtask

  task automatic t_reset();
    rd(4'h0, 4'h0, "R1 sec"); rd(4'h2, 4'h0, "R1 min"); rd(4'h4, 4'h0, "R1 hr");
    rd(4'h6, 4'h1, "R1 day"); rd(4'h8, 4'h1, "R1 mon"); rd(4'hA, 4'h0, "R1 yr");
    rd(4'hC, 4'h0, "R1 wday"); rd(4'hD, 4'h0, "R1 ctlD"); rd(4'hE, 4'h0, "R1 ctlE");
    rd(4'hF, 4'h4, "R1 ctlF");
  endtask

  task automatic t_map();
    wr(4'hF, 4'hC); rd(4'hF, 4'hC, "R2 test bit stored");
    wr(4'hF, 4'h4);
    wr(4'hB, 4'h7); rd(4'hB, 4'h7, "R2 year tens readback");
  endtask

  task automatic t_rollover();
    set_all(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd8, 4'd2, 4'd8, 4'd0, 4'd2, 4'd2, 4'd3, 4'd6);
    tick1(); rd(4'h0, 4'd9, "R3 sec 59"); rd(4'h6, 4'd8, "R3 day held");
    tick1();
    rd(4'h0, 4'd0, "R3 sec wrap"); rd(4'h1, 4'd0, "R3 sec tens");
    rd(4'h2, 4'd0, "R3 min"); rd(4'h3, 4'd0, "R3 min tens");
    rd(4'h4, 4'd0, "R3 hr"); rd(4'h5, 4'd0, "R3 hr tens");
    rd(4'h7, 4'd0, "R4 feb28 day tens"); rd(4'h6, 4'd1, "R4 feb28 day");
    rd(4'h8, 4'd3, "R4 month"); rd(4'hC, 4'd0, "R3 weekday wrap");
    rd(4'hA, 4'd3, "R3 year kept");
    set_all(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9, 4'd2, 4'd8, 4'd0, 4'd2, 4'd2, 4'd4, 4'd1);
    tick1(); rd(4'h7, 4'd2, "R4 leap tens"); rd(4'h6, 4'd9, "R4 leap day");
    rd(4'h8, 4'd2, "R4 leap month"); rd(4'hC, 4'd2, "R3 weekday step");
    set_all(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9, 4'd2, 4'd9, 4'd0, 4'd2, 4'd2, 4'd4, 4'd1);
    tick1(); rd(4'h6, 4'd1, "R4 leap end"); rd(4'h8, 4'd3, "R4 leap to march");
    set_all(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9, 4'd3, 4'd0, 4'd0, 4'd4, 4'd2, 4'd4, 4'd1);
    tick1(); rd(4'h6, 4'd1, "R4 april end"); rd(4'h8, 4'd5, "R4 may");
    set_all(4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9, 4'd3, 4'd1, 4'd1, 4'd2, 4'd9, 4'd9, 4'd1);
    tick1();
    rd(4'hB, 4'd0, "R3 year tens wrap"); rd(4'hA, 4'd0, "R3 year wrap");
    rd(4'h9, 4'd0, "R3 month tens"); rd(4'h8, 4'd1, "R3 january");
    rd(4'h7, 4'd0, "R3 dec31 tens"); rd(4'h6, 4'd1, "R3 dec31 day");
  endtask

  task automatic t_twelve();
    wr(4'hF, 4'h0);
    set_all(4'h5, 4'd1, 4'd5, 4'd9, 4'd5, 4'd9, 4'd1, 4'd0, 4'd0, 4'd5, 4'd2, 4'd4, 4'd0);
    tick1();
    rd(4'h5, 4'h1, "R5 midnight am"); rd(4'h4, 4'd2, "R5 midnight 12");
    rd(4'h6, 4'd1, "R5 day advance");
    wr(4'h3, 4'd5); wr(4'h2, 4'd9); wr(4'h1, 4'd5); wr(4'h0, 4'd9);
    tick1();
    rd(4'h5, 4'h0, "R5 one tens"); rd(4'h4, 4'd1, "R5 one");
    wr(4'h5, 4'h1); wr(4'h4, 4'd1);
    wr(4'h3, 4'd5); wr(4'h2, 4'd9); wr(4'h1, 4'd5); wr(4'h0, 4'd9);
    tick1();
    rd(4'h5, 4'h5, "R5 noon pm"); rd(4'h4, 4'd2, "R5 noon 12");
    rd(4'h6, 4'd1, "R5 noon keeps day");
    wr(4'hF, 4'h4);
  endtask

  task automatic t_hold();
    wr(4'h1, 4'd1); wr(4'h0, 4'd0);
    wr(4'hD, 4'h1);
    tick1(); tick1();
    rd(4'h0, 4'd0, "R6 frozen");
    rd(4'hD, 4'h3, "R6 busy while pending");
    wr(4'hD, 4'h0);
    rd(4'h0, 4'd1, "R6 one step on release");
    rd(4'hD, 4'h2, "R7 busy after update");
    repeat (2) @(negedge clk);
    rd(4'hD, 4'h0, "R7 busy drops");
  endtask

  task automatic t_adjust();
    wr(4'h3, 4'd1); wr(4'h2, 4'd0); wr(4'h1, 4'd4); wr(4'h0, 4'd5);
    wr(4'hD, 4'h8);
    rd(4'h0, 4'd0, "R8 sec zero"); rd(4'h1, 4'd0, "R8 sec tens zero");
    rd(4'h2, 4'd1, "R8 minute up");
    repeat (6) @(negedge clk);
    rd(4'hD, 4'h0, "R8 request cleared");
    wr(4'h1, 4'd1); wr(4'h0, 4'd5);
    wr(4'hD, 4'h8);
    rd(4'h0, 4'd0, "R8 low sec zero"); rd(4'h2, 4'd1, "R8 minute kept");
    repeat (6) @(negedge clk);
  endtask

  task automatic t_stop_reset();
    wr(4'h1, 4'd0); wr(4'h0, 4'd5);
    wr(4'hF, 4'h6); tick1();
    rd(4'h0, 4'd5, "R9 stop ignores tick");
    wr(4'hF, 4'h5);
    rd(4'h0, 4'd0, "R10 reset clears sec");
    tick1(); rd(4'h0, 4'd0, "R10 no count in reset");
    wr(4'hF, 4'h4);
  endtask

  task automatic t_irq();
    wr(4'hE, 4'h6); wr(4'h1, 4'd0); wr(4'h0, 4'd0);
    tick1(); irq_chk(1'b1, "R11 second event");
    repeat (6) @(negedge clk);
    rd(4'hD, 4'h4, "R11 flag bit");
    tick64(); irq_chk(1'b1, "R12 latched");
    wr(4'hD, 4'h0); irq_chk(1'b0, "R12 host clear");
    wr(4'hE, 4'h7); tick1(); irq_chk(1'b0, "R13 masked");
    repeat (6) @(negedge clk);
    rd(4'hD, 4'h4, "R13 flag set under mask");
    wr(4'hD, 4'h0);
    wr(4'hE, 4'hA); wr(4'h1, 4'd3); wr(4'h0, 4'd0);
    tick1(); irq_chk(1'b0, "R11 minute no event");
    wr(4'h1, 4'd5); wr(4'h0, 4'd9);
    tick1(); irq_chk(1'b1, "R11 minute event");
    wr(4'hD, 4'h0);
    wr(4'hE, 4'hE); wr(4'h3, 4'd5); wr(4'h2, 4'd8); wr(4'h1, 4'd5); wr(4'h0, 4'd9);
    tick1(); irq_chk(1'b0, "R11 hour no event");
    wr(4'h2, 4'd9); wr(4'h1, 4'd5); wr(4'h0, 4'd9);
    tick1(); irq_chk(1'b1, "R11 hour event");
    wr(4'hD, 4'h0);
    wr(4'hE, 4'h4); tick1(); irq_chk(1'b1, "R12 pulse set");
    tick64(); irq_chk(1'b0, "R12 pulse ends");
    wr(4'hE, 4'h2); tick64(); irq_chk(1'b1, "R11 64Hz event");
    wr(4'hD, 4'h0); irq_chk(1'b0, "R12 64Hz cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_rollover();
    t_twelve();
    t_hold();
    t_adjust();
    t_stop_reset();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule